// File: doc/BRIEF.md
# JTAG serial port exchange

This block is the target-side end of a byte-stream console carried over one JTAG data register. Each complete data-register scan is a fixed 72-bit full-duplex frame. The host shifts in a header byte and eight byte slots. At the same time the block shifts out its own header byte and up to eight bytes for the host. The host's header says how many of its slots carry data. The returned header says how many returned slots carry data and how much room the receive side has left.

Two 8-entry byte FIFOs face the system. The receive FIFO carries host-to-target bytes and is drained one byte at a time. The transmit FIFO carries target-to-host bytes and is filled one byte at a time. The TAP controller is outside this block and supplies the capture, shift and update strobes. This block handles only the plain single-device frame. Capture, shift, update and the system-side strobes all share one clock, the test clock.

The returned header and the outgoing bytes are snapshotted at capture. FIFO contents change only at the update that ends a full-length scan, so an aborted scan changes nothing.

Top module: `jsp_exchange`

## Requirements
- R1: After reset, tdo is 0, rx_avail is 0 and tx_space is 1.
- R2: From the capture edge onward, tdo presents the returned header least significant bit first, one bit per shift cycle. Header bits 7:4 hold the number of returned bytes, which is the transmit level capped at 8. Header bits 3:0 hold the number of free receive entries.
- R3: Returned slot k occupies frame bits 8+8k to 15+8k, least significant bit first. Slots are filled in transmit FIFO order. The slot contents are fixed at capture, so bytes loaded later do not appear in that frame.
- R4: Bits 7:4 of the host header give the number of valid host slots, and values 9 to 15 count as 8. Bits 3:0 of the host header are ignored. Accepted bytes enter the receive FIFO in slot order at update.
- R5: The number of bytes accepted is the smaller of the host's count and the free count reported in that frame's header. Bytes beyond that number are dropped.
- R6: At update, exactly the bytes reported in the returned header are removed from the transmit FIFO. Bytes loaded during the scan remain for the next frame.
- R7: If an update arrives after fewer than 72 shift cycles since capture, neither FIFO changes.
- R8: Shift cycles after the 72nd are ignored, and the frame still commits at update.
- R9: tx_space goes low when the transmit FIFO holds 8 bytes. A tx_load while tx_space is low is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; every register uses its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dr_capture | input | 1 | Capture-DR strobe from the TAP |
| dr_shift | input | 1 | Shift-DR enable from the TAP |
| dr_update | input | 1 | Update-DR strobe from the TAP |
| tdi | input | 1 | Serial data from the host |
| tdo | output | 1 | Serial data to the host, registered |
| rx_byte | output | 8 | Oldest received byte |
| rx_avail | output | 1 | Receive FIFO not empty |
| rx_take | input | 1 | Removes rx_byte from the receive FIFO |
| tx_byte | input | 8 | Byte to send to the host |
| tx_load | input | 1 | Appends tx_byte to the transmit FIFO |
| tx_space | output | 1 | Transmit FIFO not full |

## Verification
The first returned bit is on tdo one edge after the capture strobe. Each later bit follows one shift edge after the previous one. The bench therefore reads tdo on the falling edge just before each shift edge, which is also when it presents tdi.

FIFO levels, rx_avail and rx_byte change on the edge that samples the update strobe or the system strobe. The bench reads them on the following falling edge. The receive scoreboard pops one expected byte per rx_take at that falling edge and compares it with rx_byte.

The frame expectations (returned count, free count, accepted count) are computed from the bench's own queue sizes just before capture. This matches the moment the design takes its snapshot.

// File: rtl/jsp_pkg.sv
package jsp_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/jsp_dr_shifter.sv
// Frame shift register with a bit counter: loads at capture, shifts right
// (LSB out, new bit in at the top) and freezes once the full frame is in.
module jsp_dr_shifter #(
  parameter int FRAME_W = 72
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_val,
  input  logic               shift,
  input  logic               sin,
  input  logic               clear,
  output logic [FRAME_W-1:0] frame,
  output logic               frame_ok,
  output logic               sout
);
  localparam int CNT_W = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sr;
  logic [CNT_W-1:0]   cnt;
  logic               armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr    <= '0;
      cnt   <= '0;
      armed <= 1'b0;
    end else if (load) begin
      sr    <= load_val;
      cnt   <= '0;
      armed <= 1'b1;
    end else if (clear) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (shift && (cnt != CNT_W'(FRAME_W))) begin
      sr  <= {sin, sr[FRAME_W-1:1]};
      cnt <= cnt + 1'b1;
    end
  end

  assign frame    = sr;
  assign frame_ok = armed && (cnt == CNT_W'(FRAME_W));
  assign sout     = sr[0];

  // R8: counter never passes the frame length
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(FRAME_W));
  // R8: once complete, extra shift cycles leave the frame untouched
  assert_extra_bits_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (shift && frame_ok && !load && !clear) |=> $stable(frame));
endmodule

// File: rtl/jsp_rx_fifo.sv
// Receive FIFO: several bytes written in one cycle, one byte read per cycle.
module jsp_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int SLOTS = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [$clog2(DEPTH+1)-1:0]      wr_n,
  input  logic [SLOTS-1:0][jsp_pkg::BYTE_W-1:0] wr_bytes,
  input  logic                            rd_en,
  output logic [jsp_pkg::BYTE_W-1:0]      rd_byte,
  output logic                            rd_valid,
  output logic [$clog2(DEPTH+1)-1:0]      level
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  jsp_pkg::byte_t  mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic            pop_ok;
  logic [CW-1:0]   add_n;

  assign pop_ok = rd_en && (level != '0);
  assign add_n  = wr_en ? wr_n : '0;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int i = 0; i < SLOTS; i++) begin
        if (i < int'(wr_n)) mem[AW'(wr_ptr + AW'(i))] <= wr_bytes[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      wr_ptr <= wr_ptr + AW'(add_n);
      if (pop_ok) rd_ptr <= rd_ptr + 1'b1;
      level <= level + add_n - CW'(pop_ok);
    end
  end

  assign rd_byte  = mem[rd_ptr];
  assign rd_valid = (level != '0);

  // R5: a bulk write never exceeds the room left
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (int'(level) + int'(wr_n) <= DEPTH));
  assert_level_bound_R5: assert property (@(posedge clk) disable iff (rst)
    level <= CW'(DEPTH));
endmodule

// File: rtl/jsp_tx_fifo.sv
// Transmit FIFO: one byte written per cycle, a window of SLOTS bytes visible
// from the head, several bytes removed in one cycle.
module jsp_tx_fifo #(
  parameter int DEPTH = 8,
  parameter int SLOTS = 8
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            push,
  input  logic [jsp_pkg::BYTE_W-1:0]      din,
  output logic                            ready,
  input  logic                            pop_en,
  input  logic [$clog2(DEPTH+1)-1:0]      pop_n,
  output logic [SLOTS-1:0][jsp_pkg::BYTE_W-1:0] peek,
  output logic [$clog2(DEPTH+1)-1:0]      level
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  jsp_pkg::byte_t  mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic            push_ok;
  logic [CW-1:0]   sub_n;

  assign ready   = (level != CW'(DEPTH));
  assign push_ok = push && ready;
  assign sub_n   = pop_en ? pop_n : '0;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      rd_ptr <= rd_ptr + AW'(sub_n);
      level  <= level + CW'(push_ok) - sub_n;
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_peek
    assign peek[g] = mem[AW'(rd_ptr + AW'(g))];
  end

  // R6: never removes more than it holds
  assert_pop_le_level_R6: assert property (@(posedge clk) disable iff (rst)
    pop_en |-> (pop_n <= level));
  // R9: a load into a full FIFO is dropped
  assert_full_load_dropped_R9: assert property (@(posedge clk) disable iff (rst)
    (push && (level == CW'(DEPTH)) && !pop_en) |=> $stable(level));
endmodule

// File: rtl/jsp_exchange.sv
// Full-duplex byte exchange over one fixed-length JTAG data-register frame.
module jsp_exchange #(
  parameter int DEPTH = 8,
  parameter int SLOTS = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       dr_capture,
  input  logic       dr_shift,
  input  logic       dr_update,
  input  logic       tdi,
  output logic       tdo,
  output logic [7:0] rx_byte,
  output logic       rx_avail,
  input  logic       rx_take,
  input  logic [7:0] tx_byte,
  input  logic       tx_load,
  output logic       tx_space
);
  import jsp_pkg::*;

  localparam int FRAME_W = BYTE_W * (SLOTS + 1);
  localparam int CW      = $clog2(DEPTH + 1);

  logic [CW-1:0]                 rx_level, tx_level;
  logic [SLOTS-1:0][BYTE_W-1:0]  tx_peek;
  logic [FRAME_W-1:0]            frame_q, cap_val;
  logic                          frame_ok, commit;
  logic [CW-1:0]                 tx_clip, free_now, cap_tx, cap_free;
  logic [CW-1:0]                 host_n, accept;
  logic [NIB_W-1:0]              host_nib;
  logic [BYTE_W-1:0]             ret_hdr;

  // header contents at capture time
  assign tx_clip  = (tx_level > CW'(SLOTS)) ? CW'(SLOTS) : tx_level;
  assign free_now = CW'(DEPTH) - rx_level;
  assign ret_hdr  = {NIB_W'(tx_clip), NIB_W'(free_now)};
  assign cap_val  = {tx_peek, ret_hdr};

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_tx   <= '0;
      cap_free <= '0;
    end else if (dr_capture) begin
      cap_tx   <= tx_clip;
      cap_free <= free_now;
    end
  end

  // host header decode: count in the upper nibble, capped at SLOTS
  assign host_nib = frame_q[BYTE_W-1 -: NIB_W];
  assign host_n   = (host_nib > NIB_W'(SLOTS)) ? CW'(SLOTS) : CW'(host_nib);
  assign accept   = (host_n < cap_free) ? host_n : cap_free;
  assign commit   = dr_update && frame_ok;

  jsp_dr_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (dr_capture),
    .load_val (cap_val),
    .shift    (dr_shift),
    .sin      (tdi),
    .clear    (dr_update),
    .frame    (frame_q),
    .frame_ok (frame_ok),
    .sout     (tdo)
  );

  jsp_rx_fifo #(.DEPTH(DEPTH), .SLOTS(SLOTS)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (commit),
    .wr_n     (accept),
    .wr_bytes (frame_q[FRAME_W-1:BYTE_W]),
    .rd_en    (rx_take),
    .rd_byte  (rx_byte),
    .rd_valid (rx_avail),
    .level    (rx_level)
  );

  jsp_tx_fifo #(.DEPTH(DEPTH), .SLOTS(SLOTS)) u_tx (
    .clk    (clk),
    .rst    (rst),
    .push   (tx_load),
    .din    (tx_byte),
    .ready  (tx_space),
    .pop_en (commit),
    .pop_n  (cap_tx),
    .peek   (tx_peek),
    .level  (tx_level)
  );

  // R7: an update that ends a short scan leaves the receive level alone
  assert_abort_rx_still_R7: assert property (@(posedge clk) disable iff (rst)
    (dr_update && !frame_ok && !rx_take) |=> $stable(rx_level));
  // R7: and the transmit level only grows by a system load
  assert_abort_tx_still_R7: assert property (@(posedge clk) disable iff (rst)
    (dr_update && !frame_ok && !tx_load) |=> $stable(tx_level));
endmodule

// File: tb/jsp_exchange_bench.sv
module jsp_exchange_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       dr_capture = 1'b0, dr_shift = 1'b0, dr_update = 1'b0, tdi = 1'b0;
  logic       tdo;
  logic [7:0] rx_byte;
  logic       rx_avail;
  logic       rx_take = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic       tx_load = 1'b0;
  logic       tx_space;

  always #5 clk = ~clk;

  jsp_exchange u_jsp_exchange (
    .clk(clk), .rst(rst), .dr_capture(dr_capture), .dr_shift(dr_shift),
    .dr_update(dr_update), .tdi(tdi), .tdo(tdo), .rx_byte(rx_byte),
    .rx_avail(rx_avail), .rx_take(rx_take), .tx_byte(tx_byte),
    .tx_load(tx_load), .tx_space(tx_space)
  );

  int vectors = 0;
  int fails   = 0;
  logic [7:0] tq [$];   // model of the transmit FIFO
  logic [7:0] sb [$];   // expected receive bytes (scoreboard)
  int pop_budget = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the receive FIFO and compares against the scoreboard
  always @(negedge clk) begin
    if (pop_budget > 0 && rx_avail) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R4 unexpected rx byte", {24'h0, rx_byte}, 32'h0);
        pop_budget = 0;
        rx_take <= 1'b0;
      end else begin
        logic [7:0] e;
        e = sb.pop_front();
        chk(rx_byte == e, "R4 rx byte order", {24'h0, rx_byte}, {24'h0, e});
        pop_budget = pop_budget - 1;
        rx_take <= 1'b1;
      end
    end else begin
      rx_take <= 1'b0;
    end
  end

  task automatic drain(input int n);
    pop_budget = n;
    wait (pop_budget == 0);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic push(input logic [7:0] d);
    bit rdy;
    @(negedge clk);
    rdy = tx_space;
    tx_load = 1'b1;
    tx_byte = d;
    @(negedge clk);
    tx_load = 1'b0;
    if (rdy) tq.push_back(d);
  endtask

  function automatic logic [71:0] mk(input logic [7:0] hdr, input logic [7:0] seed);
    logic [71:0] f;
    f[7:0] = hdr;
    for (int k = 0; k < 8; k++) f[8+8*k +: 8] = seed + 8'(k * 17);
    return f;
  endfunction

  task automatic scan(input logic [71:0] fin, input int nbits, input string tag);
    int etx, efree, sent, acc;
    logic [71:0] rb;
    etx   = (tq.size() > 8) ? 8 : tq.size();
    efree = 8 - sb.size();
    sent  = (fin[7:4] > 4'd8) ? 8 : int'(fin[7:4]);
    acc   = (sent < efree) ? sent : efree;
    rb    = '0;
    @(negedge clk);
    dr_capture = 1'b1;
    @(negedge clk);
    dr_capture = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      if (i < 72) rb[i] = tdo;
      dr_shift = 1'b1;
      tdi = (i < 72) ? fin[i] : 1'b0;
      @(negedge clk);
    end
    dr_shift  = 1'b0;
    dr_update = 1'b1;
    @(negedge clk);
    dr_update = 1'b0;
    chk(rb[7:0] == {4'(etx), 4'(efree)}, {"R2 header ", tag},
        {24'h0, rb[7:0]}, {24'h0, 4'(etx), 4'(efree)});
    for (int j = 0; j < etx; j++)
      chk(rb[8+8*j +: 8] == tq[j], {"R3 returned slot ", tag},
          {24'h0, rb[8+8*j +: 8]}, {24'h0, tq[j]});
    if (nbits >= 72) begin
      repeat (etx) void'(tq.pop_front());
      for (int j = 0; j < acc; j++) sb.push_back(fin[8+8*j +: 8]);
    end
    chk(rx_avail == (sb.size() != 0), {"R5 rx level after scan ", tag},
        {31'h0, rx_avail}, {31'h0, sb.size() != 0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'h0, 32'h1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tdo == 1'b0, "R1 tdo", {31'h0, tdo}, 32'h0);
    chk(rx_avail == 1'b0, "R1 rx_avail", {31'h0, rx_avail}, 32'h0);
    chk(tx_space == 1'b1, "R1 tx_space", {31'h0, tx_space}, 32'h1);

    // R2: idle frame, nothing either way
    scan(mk(8'h00, 8'h10), 72, "R2 idle");

    // R3/R4: three bytes each way
    push(8'hA1); push(8'hB2); push(8'hC3);
    scan(mk(8'h30, 8'h11), 72, "R3 three each way");
    drain(sb.size());
    chk(rx_avail == 1'b0, "R4 drained", {31'h0, rx_avail}, 32'h0);

    // R3/R6: byte loaded mid-scan stays for the next frame
    push(8'hA0); push(8'hA1);
    fork
      scan(mk(8'h00, 8'h20), 72, "R3 capture snapshot");
      begin
        repeat (20) @(negedge clk);
        push(8'h5A);
      end
    join
    scan(mk(8'h00, 8'h21), 72, "R6 leftover byte");
    scan(mk(8'h00, 8'h22), 72, "R6 tx emptied");

    // R5: fill receive side, then overfill, then partial accept
    scan(mk(8'h80, 8'h30), 72, "R5 fill");
    scan(mk(8'h30, 8'h40), 72, "R5 no room");
    drain(3);
    scan(mk(8'h5F, 8'h50), 72, "R5 partial accept, R4 low nibble ignored");
    drain(sb.size());
    chk(rx_avail == 1'b0, "R5 drained", {31'h0, rx_avail}, 32'h0);

    // R4: count above 8 treated as 8
    scan(mk(8'hF0, 8'h60), 72, "R4 clamp");
    drain(sb.size());

    // R7: aborted scan
    push(8'h77);
    scan(mk(8'h40, 8'h70), 40, "R7 abort");
    chk(rx_avail == 1'b0, "R7 no rx push", {31'h0, rx_avail}, 32'h0);
    scan(mk(8'h00, 8'h71), 72, "R7 tx kept after abort");

    // R8: extra shift cycles
    scan(mk(8'h20, 8'hFF), 73, "R8 one extra bit");
    scan(mk(8'h20, 8'h81), 80, "R8 eight extra bits");
    drain(sb.size());

    // R9: transmit FIFO full
    for (int k = 0; k < 8; k++) push(8'hC0 + 8'(k));
    chk(tx_space == 1'b0, "R9 tx_space low when full", {31'h0, tx_space}, 32'h0);
    push(8'hEE);
    scan(mk(8'h00, 8'h90), 72, "R9 full frame out");
    scan(mk(8'h00, 8'h91), 72, "R9 dropped byte absent");
    chk(tx_space == 1'b1, "R9 tx_space back", {31'h0, tx_space}, 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule